// File: doc/BRIEF.md
# Cascadable Serial Channel-Control Front End

This block is the serial front end of a four-channel low-side gate predriver. A host drives a chip select, a serial clock and a serial data line. While the select is low, four channel-enable bits shift in and four per-channel fault bits shift out. The fault bits are a snapshot taken at the moment the select fell. When the select returns high, the last four received bits are committed to a channel latch. Each gate enable is the OR of its latch bit and a matching parallel input, so a fast asynchronous path can override the serial one.

The serial pins are sampled in the block's own clock domain. A short synchronizer and edge detectors sit in front of the shift logic. The serial data output is released only while the select is low. It changes on serial clock falling edges, so a second device whose data input is wired to this output samples stable data. Several devices share the select and serial clock and form a daisy chain, with four bits per device in each frame. The device nearest the host keeps the last four bits of the frame.

Top module: `psi_serial_front`

## Requirements
- R1: While the power-on reset is active, and after it ends, the channel latch is zero. Each `gate_en` bit then equals `par_en`, and `sdo_oe` is low.
- R2: `sdo_oe` goes high after `cs_n` falls and low after `cs_n` rises. While it is low, `sdo` is high impedance.
- R3: When `cs_n` falls, `fault_in` is copied into the shift register. Before the first `sclk` rising edge, `sdo` shows `fault_in[3]`. After each `sclk` falling edge it shows the next lower fault bit.
- R4: On each `sclk` rising edge while `cs_n` is low, `sdi` enters at bit 0 of the shift register and the contents move one place toward bit 3. The bit sent first is the first bit that leaves on `sdo`.
- R5: A change on `fault_in` after `cs_n` has fallen does not alter the bits shifted out in that frame.
- R6: When `cs_n` rises, shift register bits 3..0 are copied into the channel latch. Bit i controls channel i, and 1 means on.
- R7: A frame with fewer than four `sclk` edges commits the partly shifted register. The snapshot bits that have not yet left occupy the upper positions.
- R8: `gate_en[i]` is `latch[i] | par_en[i]`, and a change on `par_en` reaches `gate_en` without a clock.
- R9: With two devices chained through `sdo`→`sdi`, an eight-bit frame gives the far device the first four bits and the near device the last four. The far device's `sdo` shows its own faults followed by the near device's faults.
- R10: Pulling `ext_rst_n` low has the same effect as the power-on reset. It clears the latch, so `gate_en` equals `par_en`.
- R11: The channel latch changes only when `cs_n` rises. `sclk` activity while `cs_n` is high leaves `gate_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial command data in |
| fault_in | input | CH | Live per-channel fault flags |
| par_en | input | CH | Parallel channel enables |
| sdo | output | 1 | Serial fault data out, high impedance when idle |
| sdo_oe | output | 1 | Drive enable of `sdo` |
| gate_en | output | CH | Channel gate enables |

## Verification
Several properties are checked on every clock. The snapshot load on a select fall, the one-place shift with the new bit at the bottom on a serial clock rise, the commit of the register into the latch on a select rise and the latch holding at all other times are all checked this way. So are the output-enable tracking of the select and the property that a set parallel input always shows on its gate enable. Other behaviours can only be shown by bench scenarios. These are the order in which fault bits appear on `sdo` across a whole frame and the immunity to faults that arrive mid-frame. The contents committed by short and long frames and the split of an eight-bit frame across two chained devices are also bench scenarios. The bench compares all of these against a chain model it keeps itself.

// File: rtl/psi_pkg.sv
package psi_pkg;
  // Default channel count and synchronizer depth for the serial front end.
  localparam int unsigned PSI_CH_DEFAULT   = 4;
  localparam int unsigned PSI_SYNC_DEFAULT = 2;
endpackage

// File: rtl/psi_sync.sv
// Multi-flop synchronizer for asynchronous pins, reset to RST_VAL.
module psi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{{W{RST_VAL}}}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/psi_edge.sv
// Synchronized single pin with rise / fall pulses.
module psi_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  psi_sync #(.W(1), .STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/psi_shift_core.sv
// Snapshot / shift register and the registered serial output bit.
module psi_shift_core #(
  parameter int unsigned CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          cs_fall,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi_s,
  input  logic [CH-1:0] fault_s,
  output logic [CH-1:0] shreg,
  output logic          sdo_bit
);
  function automatic logic [CH-1:0] shift_in(input logic [CH-1:0] r, input logic b);
    return {r[CH-2:0], b};
  endfunction

  logic do_shift, do_out;
  assign do_shift = cs_act & sclk_rise & ~cs_fall;
  assign do_out   = cs_act & sclk_fall & ~cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (cs_fall)  shreg <= fault_s;
    else if (do_shift) shreg <= shift_in(shreg, sdi_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sdo_bit <= 1'b0;
    else if (cs_fall) sdo_bit <= fault_s[CH-1];
    else if (do_out)  sdo_bit <= shreg[CH-1];
  end

  // R3
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (shreg == $past(fault_s)) && (sdo_bit == $past(fault_s[CH-1])));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> (shreg[CH-1:1] == $past(shreg[CH-2:0])) && (shreg[0] == $past(sdi_s)));
endmodule

// File: rtl/psi_out_latch.sv
// Channel latch committed on select release, ORed with the parallel path.
module psi_out_latch #(
  parameter int unsigned CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_rise,
  input  logic [CH-1:0] shreg,
  input  logic [CH-1:0] par_en,
  output logic [CH-1:0] gate_en
);
  logic [CH-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (cs_rise) latch_q <= shreg;
  end

  for (genvar i = 0; i < CH; i++) begin : g_or
    assign gate_en[i] = latch_q[i] | par_en[i];
  end

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> latch_q == $past(shreg));

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(latch_q));

  // R8
  par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & par_en) == par_en);
endmodule

// File: rtl/psi_serial_front.sv
// Top: cascadable serial channel-control front end.
module psi_serial_front
  import psi_pkg::*;
#(
  parameter int unsigned CH   = PSI_CH_DEFAULT,
  parameter int unsigned SYNC = PSI_SYNC_DEFAULT
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ext_rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic [CH-1:0] fault_in,
  input  logic [CH-1:0] par_en,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [CH-1:0] gate_en
);
  logic rst_n;
  assign rst_n = por_n & ext_rst_n;

  logic cs_lvl, cs_rise, cs_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic sdi_s;
  logic [CH-1:0] fault_s;
  logic [CH-1:0] shreg;
  logic sdo_bit;
  logic cs_act;

  psi_edge #(.STAGES(SYNC), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .pin(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  psi_edge #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(rst_n), .pin(sclk),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  psi_sync #(.W(1), .STAGES(SYNC), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s)
  );

  psi_sync #(.W(CH), .STAGES(SYNC), .RST_VAL(1'b0)) u_flt (
    .clk(clk), .rst_n(rst_n), .d(fault_in), .q(fault_s)
  );

  assign cs_act = ~cs_lvl;

  psi_shift_core #(.CH(CH)) u_core (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .fault_s(fault_s), .shreg(shreg), .sdo_bit(sdo_bit)
  );

  psi_out_latch #(.CH(CH)) u_latch (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .shreg(shreg),
    .par_en(par_en), .gate_en(gate_en)
  );

  assign sdo_oe = cs_act;
  assign sdo    = sdo_oe ? sdo_bit : 1'bz;

  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo_oe);

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);

  // R4
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cs_lvl && !cs_rise) |=> $stable(shreg));
endmodule

// File: tb/psi_serial_front_tb.sv
module psi_serial_front_tb;
  localparam int CH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, ext_rst_n, cs_n, sclk, sdi;
  logic [CH-1:0] flt0, flt1, par0, par1, gate0, gate1;
  wire  sdo0, sdo1, oe0, oe1;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_chain;
  logic [3:0] exp_lat0, exp_lat1;

  psi_serial_front #(.CH(CH)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .fault_in(flt0), .par_en(par0),
    .sdo(sdo0), .sdo_oe(oe0), .gate_en(gate0)
  );

  psi_serial_front #(.CH(CH)) u_dut_far (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdo0), .fault_in(flt1), .par_en(par1),
    .sdo(sdo1), .sdo_oe(oe1), .gate_en(gate1)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench model of the chain: one 8-bit register, near device in the low nibble.
  function automatic logic [7:0] chain_shift(input logic [7:0] s, input logic b);
    return {s[6:0], b};
  endfunction

  task automatic run_frame(input int nbits, input logic [15:0] bits,
                           input logic [3:0] f0_mid, input logic [3:0] f1_mid, input string tag);
    logic [15:0] obs0, obs1, exp0, exp1;
    obs0 = '0; obs1 = '0; exp0 = '0; exp1 = '0;
    m_chain = {flt1, flt0};
    cs_n = 1'b0;
    waitc(8);
    chk(oe0 && oe1, {tag, " R2 oe on"}, {14'd0, oe1, oe0}, 16'h3);
    flt0 = f0_mid; flt1 = f1_mid;  // R5: changes after the snapshot
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[nbits-1-i];
      waitc(4);
      obs0[i] = sdo0; obs1[i] = sdo1;
      exp0[i] = m_chain[3]; exp1[i] = m_chain[7];
      m_chain = chain_shift(m_chain, bits[nbits-1-i]);
      sclk = 1'b1;
      waitc(8);
      sclk = 1'b0;
      waitc(4);
    end
    chk(obs0 == exp0, {tag, " R3 R4 R5 near sdo"}, obs0, exp0);
    chk(obs1 == exp1, {tag, " R9 far sdo"}, obs1, exp1);
    cs_n = 1'b1;
    waitc(8);
    exp_lat0 = m_chain[3:0];
    exp_lat1 = m_chain[7:4];
    chk(!oe0 && !oe1, {tag, " R2 oe off"}, {14'd0, oe1, oe0}, 16'h0);
    chk(gate0 == (exp_lat0 | par0), {tag, " R6 R7 R8 near gate"}, {12'd0, gate0}, {12'd0, exp_lat0 | par0});
    chk(gate1 == (exp_lat1 | par1), {tag, " R6 R9 far gate"}, {12'd0, gate1}, {12'd0, exp_lat1 | par1});
  endtask

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    flt0 = '0; flt1 = '0; par0 = '0; par1 = '0;
    exp_lat0 = '0; exp_lat1 = '0;
    void'($urandom(32'h5EED_0042));
    waitc(3);
    // R1: state during reset
    chk(gate0 == 4'h0 && !oe0, "R1 in reset", {11'd0, oe0, gate0}, 16'h0);
    por_n = 1'b1;
    waitc(4);
    chk(gate0 == 4'h0 && gate1 == 4'h0 && !oe0 && !oe1, "R1 after reset",
        {6'd0, oe1, oe0, gate1, gate0}, 16'h0);

    // Directed: full four-bit frame, faults snapshot, mid-frame fault change (R5)
    flt0 = 4'b1010; flt1 = 4'b0110;
    run_frame(4, 16'h000B, 4'b0101, 4'b1001, "dir4");
    // R7: short frame of two bits
    flt0 = 4'b1100; flt1 = 4'b0011;
    run_frame(2, 16'h0001, 4'b0000, 4'b1111, "short2");
    // R9: cascade eight-bit frame
    flt0 = 4'b0001; flt1 = 4'b1000;
    run_frame(8, 16'h00C5, 4'b1110, 4'b0111, "casc8");

    // R8: parallel path reaches gate without a serial frame
    par0 = 4'b0110;
    #1;
    chk(gate0 == (exp_lat0 | 4'b0110), "R8 parallel OR", {12'd0, gate0}, {12'd0, exp_lat0 | 4'b0110});
    waitc(1);
    par0 = 4'b0000;
    #1;
    chk(gate0 == exp_lat0, "R8 parallel release", {12'd0, gate0}, {12'd0, exp_lat0});
    waitc(1);

    // R11: sclk toggling with select high leaves the latch alone
    sdi = 1'b1;
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b1; waitc(8); sclk = 1'b0; waitc(8);
    end
    chk(gate0 == exp_lat0 && gate1 == exp_lat1, "R11 idle sclk",
        {8'd0, gate1, gate0}, {8'd0, exp_lat1, exp_lat0});

    // Random frames
    for (int r = 0; r < 40; r++) begin
      int nb;
      logic [15:0] bits;
      nb   = 1 + int'($urandom_range(7));
      bits = 16'($urandom);
      flt0 = 4'($urandom); flt1 = 4'($urandom);
      par0 = ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0;
      par1 = ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0;
      run_frame(nb, bits, 4'($urandom), 4'($urandom), "rand");
    end

    // R10: external reset clears the latch
    par0 = 4'h0; par1 = 4'h0;
    flt0 = 4'h0; flt1 = 4'h0;
    run_frame(8, 16'h00FF, 4'h0, 4'h0, "pre_rst");
    ext_rst_n = 1'b0;
    waitc(3);
    ext_rst_n = 1'b1;
    waitc(4);
    exp_lat0 = '0; exp_lat1 = '0;
    chk(gate0 == 4'h0 && gate1 == 4'h0 && !oe0, "R10 ext reset",
        {7'd0, oe0, gate1, gate0}, 16'h0);
    par0 = 4'b1001;
    #1;
    chk(gate0 == 4'b1001, "R10 R1 gate equals par after reset", {12'd0, gate0}, 16'h0009);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule